// File: doc/BRIEF.md
# Data-Ready Status and Interrupt Router

This block sits between a three-axis sampling path and the register and pad logic of a sensor interface. Each sample strobe delivers one 16-bit word for each axis. For every axis the block keeps a new-data flag and an overrun flag, and it packs those flags into a status byte. It also holds one output word per axis. When block data update is on, a read of the low byte of an axis freezes that axis word until its high byte has been read.

A data-ready signal is formed from the new-data state. It can be latched, following the AND of the three new-data flags. It can instead be pulsed, lasting one quarter of a sample period that a parameter sets. Two interrupt pins each OR together the sources their own five-bit mask selects. The sources are data-ready, boot busy, FIFO overrun, FIFO full and FIFO threshold. Each pin is driven push-pull or open-drain. The first pin can also be turned into an input: it is synchronized, and each rising edge on it gives a one-cycle trigger strobe for the FIFO.

Top module: `drdy_irq_router`

## Requirements
- R1: `status` bit 7 is the OR of the three overrun flags, and bits 6, 5 and 4 are the Z, Y and X overrun flags. Bit 3 is the AND of the three new-data flags, and bits 2, 1 and 0 are the Z, Y and X new-data flags. Axis index 0 is X, 1 is Y and 2 is Z, in both the strobe vectors and the packed data words (X at bits 15:0).
- R2: A sample strobe sets all three new-data flags in the next cycle. A high-byte read strobe of an axis clears that axis flag, unless a sample arrives in the same cycle.
- R3: An axis overrun flag sets when a sample arrives while that axis new-data flag is set and no high-byte read of that axis happens in the same cycle. A high-byte read of the axis clears its overrun flag.
- R4: With block data update off, every sample strobe loads all three output words in the next cycle.
- R5: With block data update on, a low-byte read of an axis freezes that axis output word against later samples. The high-byte read of that axis unfreezes it, and in the next cycle the word shows the most recent sample. Axes that have not been frozen keep updating.
- R6: In latched mode, data-ready equals the AND of the new-data flags. The pin outputs are registered, so they follow their sources one cycle later.
- R7: In pulsed mode, data-ready is high for PERIOD_CYC/4 cycles after each sample strobe, which is 4 cycles at the default.
- R8: Each pin is active when any source selected by its mask is active. The mask bits are: 0 data-ready, 1 boot busy, 2 FIFO overrun, 3 FIFO full, 4 FIFO threshold.
- R9: In push-pull mode a pin has output enable 1 and drives its active level. In open-drain mode it drives 0 with output enable equal to the active level, so it never drives high.
- R10: When `pin1_as_trig` is 1, pin 1 output enable is 0 from the next cycle. A rising edge on `pin1_in` then gives exactly one `trig_stb` cycle, two to three cycles after the edge. When `pin1_as_trig` is 0, `trig_stb` stays low.
- R11: After reset, the status byte and the output words are 0, and both pins drive 0 with output enable 1 under the default configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | New sample for all axes |
| sample_data | input | 48 | Packed samples, X at bits 15:0 |
| rd_lo | input | 3 | Low-byte read strobe per axis |
| rd_hi | input | 3 | High-byte read strobe per axis |
| bdu_en | input | 1 | Block data update enable |
| drdy_pulsed | input | 1 | 1 selects pulsed data-ready |
| boot_busy | input | 1 | Boot status source |
| fifo_ovr | input | 1 | FIFO overrun flag |
| fifo_full | input | 1 | FIFO full flag |
| fifo_thr | input | 1 | FIFO threshold flag |
| pin1_mask | input | 5 | Source enables of pin 1 |
| pin2_mask | input | 5 | Source enables of pin 2 |
| pin1_od | input | 1 | Pin 1 open-drain select |
| pin2_od | input | 1 | Pin 2 open-drain select |
| pin1_as_trig | input | 1 | Use pin 1 as trigger input |
| pin1_in | input | 1 | Pin 1 pad input value |
| status | output | 8 | Status byte |
| out_words | output | 48 | Held output words |
| pin1_drive | output | 1 | Pin 1 drive value |
| pin1_oe | output | 1 | Pin 1 output enable |
| pin2_drive | output | 1 | Pin 2 drive value |
| pin2_oe | output | 1 | Pin 2 output enable |
| trig_stb | output | 1 | One-cycle FIFO trigger strobe |

## Verification
The bench aims at a sample that lands in the same cycle as a high-byte read. A design that ignores the read there would raise a false overrun, and one that lets the read win would lose the new-data flag. It freezes one axis under block data update and sends a second sample. A design that lacks the hold shows the new word early, and one that lacks the unfreeze reload keeps the stale word after the high-byte read. It counts the width of the pulsed data-ready and the number of trigger strobes per edge, which catches an off-by-one in the pulse counter and a level-driven trigger. Open-drain and input modes are checked for any cycle in which the pad is driven high, or driven at all.

// File: rtl/drdy_pkg.sv
package drdy_pkg;
  localparam int N_AXES = 3;
  localparam int DATA_W = 16;
  localparam int N_SRC  = 5;
  localparam int SRC_DRDY  = 0;
  localparam int SRC_BOOT  = 1;
  localparam int SRC_FOVR  = 2;
  localparam int SRC_FFULL = 3;
  localparam int SRC_FTHR  = 4;
endpackage

// File: rtl/axis_track.sv
module axis_track #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_stb,
  input  logic [DW-1:0] sample_val,
  input  logic          rd_lo,
  input  logic          rd_hi,
  input  logic          bdu_en,
  output logic          new_data,
  output logic          overrun,
  output logic [DW-1:0] word
);
  logic          nd_q, nd_d, ov_q, ov_d, frz_q, frz_d;
  logic [DW-1:0] raw_q, raw_d, word_q, word_d;
  logic          hold, release_w;

  always_comb begin
    nd_d = sample_stb | (nd_q & ~rd_hi);
    ov_d = rd_hi ? 1'b0 : (ov_q | (sample_stb & nd_q));
    if (!bdu_en || rd_hi) frz_d = 1'b0;
    else if (rd_lo)       frz_d = 1'b1;
    else                  frz_d = frz_q;
    hold      = bdu_en & (frz_q | rd_lo) & ~rd_hi;
    release_w = frz_q & (rd_hi | ~bdu_en);
    raw_d     = sample_stb ? sample_val : raw_q;
    word_d    = word_q;
    if (sample_stb && !hold) word_d = sample_val;
    else if (release_w)      word_d = raw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nd_q   <= 1'b0;
      ov_q   <= 1'b0;
      frz_q  <= 1'b0;
      raw_q  <= '0;
      word_q <= '0;
    end else begin
      nd_q   <= nd_d;
      ov_q   <= ov_d;
      frz_q  <= frz_d;
      raw_q  <= raw_d;
      word_q <= word_d;
    end
  end

  assign new_data = nd_q;
  assign overrun  = ov_q;
  assign word     = word_q;

  // R3: an overrun only follows a cycle in which unread data was present
  a_r3_ovr_after_unread: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ov_q) |-> $past(nd_q));
  // R2: a sample always leaves new data flagged
  a_r2_new_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> nd_q);
  // R5: a frozen word does not move until its high byte is read
  a_r5_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bdu_en && frz_q && !rd_hi) |=> $stable(word_q));
endmodule

// File: rtl/drdy_shaper.sv
module drdy_shaper #(
  parameter int PERIOD_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_stb,
  input  logic pulsed,
  input  logic all_new,
  output logic drdy
);
  localparam int PULSE_CYC = (PERIOD_CYC / 4 < 1) ? 1 : PERIOD_CYC / 4;
  localparam int CW        = $clog2(PULSE_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (sample_stb)         cnt_d = CW'(PULSE_CYC);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign drdy = pulsed ? (cnt_q != '0) : all_new;

  // R7: the pulse counter never exceeds the quarter-period length
  a_r7_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(PULSE_CYC));
endmodule

// File: rtl/irq_pin.sv
module irq_pin #(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] mask,
  input  logic            open_drain,
  input  logic            as_input,
  output logic            pad_drive,
  output logic            pad_oe
);
  logic active;
  logic drv_q, drv_d, oe_q, oe_d, od_q;

  always_comb begin
    active = |(src & mask);
    if (as_input) begin
      drv_d = 1'b0;
      oe_d  = 1'b0;
    end else if (open_drain) begin
      drv_d = 1'b0;
      oe_d  = active;
    end else begin
      drv_d = active;
      oe_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= 1'b0;
      oe_q  <= 1'b0;
      od_q  <= 1'b0;
    end else begin
      drv_q <= drv_d;
      oe_q  <= oe_d;
      od_q  <= open_drain;
    end
  end

  assign pad_drive = drv_q;
  assign pad_oe    = oe_q;

  // R9: open-drain mode never drives the pad high
  a_r9_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    od_q |-> !(drv_q && oe_q));
  // R10: input mode releases the pad on the next cycle
  a_r10_input_released: assert property (@(posedge clk) disable iff (!rst_n)
    as_input |=> !oe_q);
endmodule

// File: rtl/trig_sync.sv
module trig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_in,
  input  logic enable,
  output logic trig_stb
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pad_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign trig_stb = enable & s2_q & ~s3_q;

  // R10: a trigger strobe lasts a single cycle
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    trig_stb |=> !trig_stb);
endmodule

// File: rtl/drdy_irq_router.sv
module drdy_irq_router
  import drdy_pkg::*;
#(
  parameter int PERIOD_CYC = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sample_stb,
  input  logic [N_AXES*DATA_W-1:0] sample_data,
  input  logic [N_AXES-1:0]        rd_lo,
  input  logic [N_AXES-1:0]        rd_hi,
  input  logic                     bdu_en,
  input  logic                     drdy_pulsed,
  input  logic                     boot_busy,
  input  logic                     fifo_ovr,
  input  logic                     fifo_full,
  input  logic                     fifo_thr,
  input  logic [N_SRC-1:0]         pin1_mask,
  input  logic [N_SRC-1:0]         pin2_mask,
  input  logic                     pin1_od,
  input  logic                     pin2_od,
  input  logic                     pin1_as_trig,
  input  logic                     pin1_in,
  output logic [7:0]               status,
  output logic [N_AXES*DATA_W-1:0] out_words,
  output logic                     pin1_drive,
  output logic                     pin1_oe,
  output logic                     pin2_drive,
  output logic                     pin2_oe,
  output logic                     trig_stb
);
  logic [N_AXES-1:0] nd, ov;
  logic              drdy;
  logic [N_SRC-1:0]  src;

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    axis_track #(.DW(DATA_W)) u_axis (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_stb (sample_stb),
      .sample_val (sample_data[a*DATA_W +: DATA_W]),
      .rd_lo      (rd_lo[a]),
      .rd_hi      (rd_hi[a]),
      .bdu_en     (bdu_en),
      .new_data   (nd[a]),
      .overrun    (ov[a]),
      .word       (out_words[a*DATA_W +: DATA_W])
    );
  end

  assign status = {|ov, ov[2], ov[1], ov[0], &nd, nd[2], nd[1], nd[0]};

  drdy_shaper #(.PERIOD_CYC(PERIOD_CYC)) u_shaper (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .pulsed     (drdy_pulsed),
    .all_new    (&nd),
    .drdy       (drdy)
  );

  always_comb begin
    src            = '0;
    src[SRC_DRDY]  = drdy;
    src[SRC_BOOT]  = boot_busy;
    src[SRC_FOVR]  = fifo_ovr;
    src[SRC_FFULL] = fifo_full;
    src[SRC_FTHR]  = fifo_thr;
  end

  irq_pin #(.NSRC(N_SRC)) u_pin1 (
    .clk        (clk),
    .rst_n      (rst_n),
    .src        (src),
    .mask       (pin1_mask),
    .open_drain (pin1_od),
    .as_input   (pin1_as_trig),
    .pad_drive  (pin1_drive),
    .pad_oe     (pin1_oe)
  );

  irq_pin #(.NSRC(N_SRC)) u_pin2 (
    .clk        (clk),
    .rst_n      (rst_n),
    .src        (src),
    .mask       (pin2_mask),
    .open_drain (pin2_od),
    .as_input   (1'b0),
    .pad_drive  (pin2_drive),
    .pad_oe     (pin2_oe)
  );

  trig_sync u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_in   (pin1_in),
    .enable   (pin1_as_trig),
    .trig_stb (trig_stb)
  );
endmodule

// File: tb/sim_drdy_irq_router.sv
`timescale 1ns/1ps
module sim_drdy_irq_router;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sample_stb;
  logic [47:0] sample_data;
  logic [2:0]  rd_lo, rd_hi;
  logic        bdu_en, drdy_pulsed, boot_busy, fifo_ovr, fifo_full, fifo_thr;
  logic [4:0]  pin1_mask, pin2_mask;
  logic        pin1_od, pin2_od, pin1_as_trig, pin1_in;
  logic [7:0]  status;
  logic [47:0] out_words;
  logic        pin1_drive, pin1_oe, pin2_drive, pin2_oe, trig_stb;

  int total = 0;
  int bad   = 0;
  bit timed_out = 0;

  always #2.5 clk = ~clk;

  drdy_irq_router u0 (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .sample_data(sample_data),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .bdu_en(bdu_en), .drdy_pulsed(drdy_pulsed),
    .boot_busy(boot_busy), .fifo_ovr(fifo_ovr), .fifo_full(fifo_full),
    .fifo_thr(fifo_thr), .pin1_mask(pin1_mask), .pin2_mask(pin2_mask),
    .pin1_od(pin1_od), .pin2_od(pin2_od), .pin1_as_trig(pin1_as_trig),
    .pin1_in(pin1_in), .status(status), .out_words(out_words),
    .pin1_drive(pin1_drive), .pin1_oe(pin1_oe), .pin2_drive(pin2_drive),
    .pin2_oe(pin2_oe), .trig_stb(trig_stb)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_sample(input logic [15:0] x, input logic [15:0] y,
                           input logic [15:0] z, input logic [2:0] hi);
    sample_data = {z, y, x};
    sample_stb  = 1'b1;
    rd_hi       = hi;
    tick();
    sample_stb  = 1'b0;
    rd_hi       = 3'b000;
  endtask

  task automatic do_read(input logic [2:0] lo, input logic [2:0] hi);
    rd_lo = lo;
    rd_hi = hi;
    tick();
    rd_lo = 3'b000;
    rd_hi = 3'b000;
  endtask

  task automatic t_reset();
    check("R11 status", status, 8'h00);
    check("R11 words", out_words, 48'h0);
    tick();
    check("R11 pin1", {pin1_drive, pin1_oe}, 2'b01);
    check("R11 pin2", {pin2_drive, pin2_oe}, 2'b01);
    check("R11 trig", trig_stb, 1'b0);
  endtask

  task automatic t_new_data();
    pin2_mask = 5'b00001;
    do_sample(16'h1111, 16'h2222, 16'h3333, 3'b000);
    check("R1 R2 status after sample", status, 8'h0F);
    check("R4 words loaded", out_words, {16'h3333, 16'h2222, 16'h1111});
    tick();
    check("R6 latched drdy on pin2", pin2_drive, 1'b1);
    do_read(3'b000, 3'b001);
    check("R2 x cleared by high read", status, 8'h06);
    tick();
    check("R6 drdy drops when AND breaks", pin2_drive, 1'b0);
    do_read(3'b000, 3'b110);
    check("R2 all cleared", status, 8'h00);
    pin2_mask = 5'b00000;
  endtask

  task automatic t_overrun();
    do_sample(16'h0001, 16'h0002, 16'h0003, 3'b000);
    do_sample(16'h0004, 16'h0005, 16'h0006, 3'b000);
    check("R3 R1 overrun on all axes", status, 8'hFF);
    do_read(3'b000, 3'b001);
    check("R3 x overrun cleared", status, 8'hE6);
    do_read(3'b000, 3'b110);
    check("R3 all cleared", status, 8'h00);
    do_sample(16'h0007, 16'h0008, 16'h0009, 3'b000);
    do_sample(16'h000A, 16'h000B, 16'h000C, 3'b001);
    check("R3 same-cycle read prevents x overrun", status, 8'hEF);
    do_read(3'b000, 3'b111);
    check("R3 R2 cleared again", status, 8'h00);
  endtask

  task automatic t_bdu();
    bdu_en = 1'b1;
    do_sample(16'hA000, 16'hA001, 16'hA002, 3'b000);
    do_read(3'b001, 3'b000);
    do_sample(16'hB000, 16'hB001, 16'hB002, 3'b000);
    check("R5 frozen x keeps old word", out_words[15:0], 16'hA000);
    check("R5 y keeps updating", out_words[31:16], 16'hB001);
    do_read(3'b000, 3'b001);
    check("R5 x shows latest after high read", out_words[15:0], 16'hB000);
    do_read(3'b000, 3'b110);
    bdu_en = 1'b0;
    do_sample(16'hC000, 16'hC001, 16'hC002, 3'b000);
    check("R4 bdu off updates", out_words, {16'hC002, 16'hC001, 16'hC000});
    do_read(3'b000, 3'b111);
  endtask

  task automatic t_pulse();
    int cnt;
    drdy_pulsed = 1'b1;
    pin2_mask   = 5'b00001;
    do_sample(16'h0, 16'h0, 16'h0, 3'b000);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      tick();
      if (pin2_drive) cnt++;
    end
    check("R7 pulse width", cnt, 4);
    check("R7 status still latched", status, 8'h0F);
    do_read(3'b000, 3'b111);
    drdy_pulsed = 1'b0;
    pin2_mask   = 5'b00000;
    tick();
  endtask

  task automatic t_mask();
    pin1_mask = 5'b00010;
    boot_busy = 1'b1;
    tick();
    check("R8 pin1 boot source", pin1_drive, 1'b1);
    check("R8 pin2 unmasked", pin2_drive, 1'b0);
    boot_busy = 1'b0;
    pin2_mask = 5'b10000;
    fifo_thr  = 1'b1;
    fifo_ovr  = 1'b1;
    tick();
    check("R8 pin2 threshold", pin2_drive, 1'b1);
    check("R8 pin1 ignores overrun", pin1_drive, 1'b0);
    fifo_thr  = 1'b0;
    pin1_mask = 5'b01000;
    fifo_full = 1'b1;
    tick();
    check("R8 pin1 full", pin1_drive, 1'b1);
    check("R8 pin2 off", pin2_drive, 1'b0);
    fifo_full = 1'b0;
    fifo_ovr  = 1'b0;
    pin1_mask = 5'b00000;
  endtask

  task automatic t_od();
    pin2_od  = 1'b1;
    fifo_thr = 1'b1;
    tick();
    check("R9 od active", {pin2_drive, pin2_oe}, 2'b01);
    fifo_thr = 1'b0;
    tick();
    check("R9 od released", {pin2_drive, pin2_oe}, 2'b00);
    pin2_od  = 1'b0;
    tick();
    check("R9 push-pull low", {pin2_drive, pin2_oe}, 2'b01);
    pin2_mask = 5'b00000;
  endtask

  task automatic t_trig();
    int cnt;
    pin1_mask    = 5'b00010;
    boot_busy    = 1'b1;
    pin1_as_trig = 1'b1;
    tick();
    check("R10 pin1 released in input mode", {pin1_drive, pin1_oe}, 2'b00);
    pin1_in = 1'b1;
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (trig_stb) cnt++;
    end
    check("R10 one strobe per edge", cnt, 1);
    pin1_in = 1'b0;
    pin1_as_trig = 1'b0;
    for (int i = 0; i < 4; i++) tick();
    pin1_in = 1'b1;
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (trig_stb) cnt++;
    end
    check("R10 no strobe when output mode", cnt, 0);
    check("R10 pin1 back to output", {pin1_drive, pin1_oe}, 2'b11);
    boot_busy = 1'b0;
  endtask

  initial begin
    #200000;
    timed_out = 1;
  end

  initial begin
    rst_n = 1'b0;
    sample_stb = 0; sample_data = '0; rd_lo = 0; rd_hi = 0;
    bdu_en = 0; drdy_pulsed = 0; boot_busy = 0; fifo_ovr = 0; fifo_full = 0;
    fifo_thr = 0; pin1_mask = 0; pin2_mask = 0; pin1_od = 0; pin2_od = 0;
    pin1_as_trig = 0; pin1_in = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    fork
      begin
        t_reset();
        t_new_data();
        t_overrun();
        t_bdu();
        t_pulse();
        t_mask();
        t_od();
        t_trig();
      end
      begin
        wait (timed_out);
        total++;
        bad++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule